// File: doc/BRIEF.md
# HD Video Output Path Selector

This block sits directly in front of the converters of a high-definition video encoder and decides, one pixel clock at a time, what sample is sent out. The sample is one of three things: the live YCrCb input pixel, a black pixel, or a pixel from a built-in test pattern. The test pattern can be a crosshatch grid or a solid field, and its colour is programmable. Live input may arrive as full 4:4:4 or as 4:2:2. For 4:2:2 input the block rebuilds a 4:4:4 output by holding the most recent chroma pair.

The block also drives a flag that marks the vertical-blanking lines open for data insertion. The line range for this flag depends on whether the 1080i or the 720p standard is selected. Settings are written through a small register port. The block holds each write as pending and applies it only at the next field boundary, so a picture never changes halfway through a field.

All sample values are 8-bit studio range. Black is Y=16, Cr=Cb=128.

Top module: `hd_out_path`

## Requirements
- R1: When the active pixel-enable bit (control bit 0) is 0, the output one cycle later is black (Y=16, Cr=128, Cb=128), whatever the input pixel is.
- R2: When pixel enable is 1, test-pattern enable (control bit 2) is 0 and the format bit (control bit 1) is 0, the input Y, Cr and Cb appear unchanged on the outputs one clock after they are sampled.
- R3: Test-pattern enable set while pixel enable is 0 gives black output, not a pattern.
- R4: With pixel enable, test-pattern enable and the frame-select bit (control bit 3) all 1, every output pixel equals the colour registers (Y at address 1, Cr at address 2, Cb at address 3).
- R5: With frame select 0, the test pattern is a crosshatch. A pixel takes the colour registers when its active column is a multiple of 64 or its active row is a multiple of 32. Every other pixel is black.
- R6: After reset the colour registers read back Y=235, Cr=128, Cb=128 (white), and the control register reads 0.
- R7: With format bit 1 (4:2:2), chroma arrives on `in_cb` only: Cb on even columns and Cr on odd columns. Each output pixel carries the newest sample of each component. Both held values start at 128 after reset. `in_cr` is ignored in this mode.
- R8: `vbi_win` goes high one cycle after a line number from 7 to 20 when `std_720p`=0, or from 6 to 25 when `std_720p`=1, but only while the VBI enable bit (control bit 4) is 1. Otherwise it is 0.
- R9: Control bits 7:5 are reserved. They read back as 0, and writing 1 to them has no effect on the output.
- R10: Register writes become pending. They take effect starting with the pixel sampled while `field_start` is high. Pixels sampled before that pulse still use the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 Y, 2 Cr, 3 Cb |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Pending value of the selected register |
| std_720p | input | 1 | Standard: 0 = 1080i, 1 = 720p |
| field_start | input | 1 | Pulse on the first pixel of a field |
| pix_col | input | 12 | Active pixel column |
| act_row | input | 11 | Active picture row |
| line_num | input | 11 | Frame line number for the VBI window |
| in_y | input | 8 | Input luma |
| in_cr | input | 8 | Input Cr (4:4:4 only) |
| in_cb | input | 8 | Input Cb, or multiplexed chroma in 4:2:2 |
| out_y | output | 8 | Output luma |
| out_cr | output | 8 | Output Cr |
| out_cb | output | 8 | Output Cb |
| vbi_win | output | 1 | VBI insertion window flag |

## Verification
The hardest case to reach from the ports is the moment a pending setting takes over. The stimulus writes a new control value and drives pixels without `field_start`, and checks that the old mode persists. It then raises `field_start` on one pixel and checks that this very pixel already follows the new mode. The 4:2:2 hold path is also hard to reach. It is driven with a column sequence whose Cb and Cr samples are all different, so the reset value of 128 shows up on the first output and each later output shows which held sample it used.

// File: rtl/hd_out_path.sv
module hd_out_path #(
  parameter int DW       = 8,
  parameter int HW       = 12,
  parameter int VW       = 11,
  parameter int HATCH_HL = 6,
  parameter int HATCH_VL = 5,
  parameter int I_VBI_LO = 7,
  parameter int I_VBI_HI = 20,
  parameter int P_VBI_LO = 6,
  parameter int P_VBI_HI = 25,
  parameter logic [DW-1:0] BLK_Y = 8'd16,
  parameter logic [DW-1:0] MID_C = 8'd128,
  parameter logic [DW-1:0] WHT_Y = 8'd235
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          std_720p,
  input  logic          field_start,
  input  logic [HW-1:0] pix_col,
  input  logic [VW-1:0] act_row,
  input  logic [VW-1:0] line_num,
  input  logic [DW-1:0] in_y,
  input  logic [DW-1:0] in_cr,
  input  logic [DW-1:0] in_cb,
  output logic [DW-1:0] out_y,
  output logic [DW-1:0] out_cr,
  output logic [DW-1:0] out_cb,
  output logic          vbi_win
);

  localparam int CTLW = 5;

  logic [CTLW-1:0] ctl_pend, ctl_act, ctl;
  logic [DW-1:0]   cy_pend, cr_pend, cb_pend;
  logic [DW-1:0]   cy_act, cr_act, cb_act;
  logic [DW-1:0]   cy, cr, cb;
  logic [DW-1:0]   hold_cr, hold_cb;
  logic [DW-1:0]   lv_cr, lv_cb;
  logic [DW-1:0]   nx_y, nx_cr, nx_cb;
  logic            pix_en, fmt422, tp_en, frame_sel, vbi_en;
  logic            on_grid, in_vbi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_pend <= '0;
      cy_pend  <= WHT_Y;
      cr_pend  <= MID_C;
      cb_pend  <= MID_C;
    end else if (reg_wr) begin
      case (reg_addr)
        2'd0: ctl_pend <= reg_wdata[CTLW-1:0];
        2'd1: cy_pend  <= reg_wdata[DW-1:0];
        2'd2: cr_pend  <= reg_wdata[DW-1:0];
        default: cb_pend <= reg_wdata[DW-1:0];
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {{(8-CTLW){1'b0}}, ctl_pend};
      2'd1:    reg_rdata = cy_pend;
      2'd2:    reg_rdata = cr_pend;
      default: reg_rdata = cb_pend;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_act <= '0;
      cy_act  <= WHT_Y;
      cr_act  <= MID_C;
      cb_act  <= MID_C;
    end else if (field_start) begin
      ctl_act <= ctl_pend;
      cy_act  <= cy_pend;
      cr_act  <= cr_pend;
      cb_act  <= cb_pend;
    end
  end

  assign ctl = field_start ? ctl_pend : ctl_act;
  assign cy  = field_start ? cy_pend  : cy_act;
  assign cr  = field_start ? cr_pend  : cr_act;
  assign cb  = field_start ? cb_pend  : cb_act;

  assign pix_en    = ctl[0];
  assign fmt422    = ctl[1];
  assign tp_en     = ctl[2];
  assign frame_sel = ctl[3];
  assign vbi_en    = ctl[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cr <= MID_C;
      hold_cb <= MID_C;
    end else if (fmt422) begin
      if (pix_col[0]) hold_cr <= in_cb;
      else            hold_cb <= in_cb;
    end
  end

  always_comb begin
    if (!fmt422) begin
      lv_cr = in_cr;
      lv_cb = in_cb;
    end else if (pix_col[0]) begin
      lv_cr = in_cb;
      lv_cb = hold_cb;
    end else begin
      lv_cr = hold_cr;
      lv_cb = in_cb;
    end
  end

  assign on_grid = (pix_col[HATCH_HL-1:0] == '0) || (act_row[HATCH_VL-1:0] == '0);

  always_comb begin
    nx_y = BLK_Y; nx_cr = MID_C; nx_cb = MID_C;
    if (pix_en) begin
      if (!tp_en) begin
        nx_y = in_y; nx_cr = lv_cr; nx_cb = lv_cb;
      end else if (frame_sel || on_grid) begin
        nx_y = cy; nx_cr = cr; nx_cb = cb;
      end
    end
  end

  assign in_vbi = std_720p
    ? (line_num >= VW'(P_VBI_LO) && line_num <= VW'(P_VBI_HI))
    : (line_num >= VW'(I_VBI_LO) && line_num <= VW'(I_VBI_HI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_y   <= BLK_Y;
      out_cr  <= MID_C;
      out_cb  <= MID_C;
      vbi_win <= 1'b0;
    end else begin
      out_y   <= nx_y;
      out_cr  <= nx_cr;
      out_cb  <= nx_cb;
      vbi_win <= vbi_en && in_vbi;
    end
  end

endmodule

// File: rtl/hd_out_path_chk.sv
module hd_out_path_chk #(
  parameter int DW = 8,
  parameter int VW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic [4:0]    ctl,
  input logic [DW-1:0] cy,
  input logic [DW-1:0] cr,
  input logic [DW-1:0] cb,
  input logic          std_720p,
  input logic [VW-1:0] line_num,
  input logic [1:0]    reg_addr,
  input logic [7:0]    reg_rdata,
  input logic [DW-1:0] out_y,
  input logic [DW-1:0] out_cr,
  input logic [DW-1:0] out_cb,
  input logic          vbi_win
);

  p_black_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[0] |=> (out_y == 8'd16 && out_cr == 8'd128 && out_cb == 8'd128));

  p_tp_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[2] && !ctl[0]) |=> (out_y == 8'd16));

  p_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[0] && ctl[2] && ctl[3]) |=>
      (out_y == $past(cy) && out_cr == $past(cr) && out_cb == $past(cb)));

  p_vbi_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[4] |=> !vbi_win);

  p_vbi_1080_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[4] && !std_720p && line_num >= 7 && line_num <= 20) |=> vbi_win);

  p_vbi_720_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (std_720p && (line_num < 6 || line_num > 25)) |=> !vbi_win);

  p_rsvd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0) |-> (reg_rdata[7:5] == 3'b000));

endmodule

bind hd_out_path hd_out_path_chk #(.DW(DW), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl(ctl), .cy(cy), .cr(cr), .cb(cb),
  .std_720p(std_720p), .line_num(line_num), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .out_y(out_y), .out_cr(out_cr), .out_cb(out_cb),
  .vbi_win(vbi_win)
);

// File: tb/hd_out_path_tb.sv
module hd_out_path_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [1:0]  reg_addr = 0;
  logic [7:0]  reg_wdata = 0;
  logic [7:0]  reg_rdata;
  logic        std_720p = 0;
  logic        field_start = 0;
  logic [11:0] pix_col = 0;
  logic [10:0] act_row = 0;
  logic [10:0] line_num = 0;
  logic [7:0]  in_y = 0, in_cr = 0, in_cb = 0;
  logic [7:0]  out_y, out_cr, out_cb;
  logic        vbi_win;

  int n_tests = 0;
  int n_fail = 0;
  logic [24:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  hd_out_path u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .std_720p(std_720p),
    .field_start(field_start), .pix_col(pix_col), .act_row(act_row),
    .line_num(line_num), .in_y(in_y), .in_cr(in_cr), .in_cb(in_cb),
    .out_y(out_y), .out_cr(out_cr), .out_cb(out_cb), .vbi_win(vbi_win)
  );

  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      logic [24:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_tests++;
      if ({out_y, out_cr, out_cb, vbi_win} !== e) begin
        n_fail++;
        $display("FAIL %s: got y=%0d cr=%0d cb=%0d vbi=%0b exp y=%0d cr=%0d cb=%0d vbi=%0b",
                 t, out_y, out_cr, out_cb, vbi_win, e[24:17], e[16:9], e[8:1], e[0]);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    reg_addr = a;
    #2;
    n_tests++;
    if (reg_rdata !== e) begin
      n_fail++;
      $display("FAIL %s: reg %0d got %0h exp %0h", t, a, reg_rdata, e);
    end
  endtask

  task automatic drive(input int col, input int row, input int line, input logic fs,
                       input logic [7:0] y, input logic [7:0] r, input logic [7:0] b,
                       input logic [7:0] ey, input logic [7:0] er, input logic [7:0] eb,
                       input logic ev, input string t);
    @(negedge clk);
    pix_col = 12'(col); act_row = 11'(row); line_num = 11'(line);
    field_start = fs; in_y = y; in_cr = r; in_cb = b;
    exp_q.push_back({ey, er, eb, ev});
    tag_q.push_back(t);
  endtask

  task automatic idle();
    @(negedge clk);
    field_start = 0;
    @(negedge clk);
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog: run did not end, exp finish got timeout");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R6 reset values
    rd_chk(2'd1, 8'd235, "R6");
    rd_chk(2'd2, 8'd128, "R6");
    rd_chk(2'd3, 8'd128, "R6");
    rd_chk(2'd0, 8'd0, "R6");
    // R1 black while disabled
    drive(5, 3, 100, 0, 8'd200, 8'd10, 8'd20, 8'd16, 8'd128, 8'd128, 0, "R1");
    drive(6, 3, 100, 1, 8'd90, 8'd250, 8'd0, 8'd16, 8'd128, 8'd128, 0, "R1");
    idle();
    // R10 pending until field_start
    wr(2'd0, 8'h01);
    drive(7, 3, 100, 0, 8'd77, 8'd66, 8'd55, 8'd16, 8'd128, 8'd128, 0, "R10");
    drive(8, 3, 100, 1, 8'd78, 8'd67, 8'd56, 8'd78, 8'd67, 8'd56, 0, "R10");
    // R2 live pass-through
    drive(9, 3, 100, 0, 8'd1, 8'd2, 8'd3, 8'd1, 8'd2, 8'd3, 0, "R2");
    drive(10, 3, 100, 0, 8'd255, 8'd0, 8'd255, 8'd255, 8'd0, 8'd255, 0, "R2");
    idle();
    // R9 reserved bits
    wr(2'd0, 8'hE1);
    rd_chk(2'd0, 8'h01, "R9");
    drive(11, 3, 100, 1, 8'd44, 8'd33, 8'd22, 8'd44, 8'd33, 8'd22, 0, "R9");
    idle();
    // R3 pattern enable alone
    wr(2'd0, 8'h0C);
    drive(0, 0, 100, 1, 8'd44, 8'd33, 8'd22, 8'd16, 8'd128, 8'd128, 0, "R3");
    idle();
    // R4 solid frame, default white then programmed
    wr(2'd0, 8'h0D);
    drive(3, 7, 100, 1, 8'd44, 8'd33, 8'd22, 8'd235, 8'd128, 8'd128, 0, "R4");
    idle();
    wr(2'd1, 8'd81); wr(2'd2, 8'd90); wr(2'd3, 8'd240);
    rd_chk(2'd2, 8'd90, "R6");
    drive(3, 7, 100, 0, 8'd44, 8'd33, 8'd22, 8'd235, 8'd128, 8'd128, 0, "R10");
    drive(4, 7, 100, 1, 8'd44, 8'd33, 8'd22, 8'd81, 8'd90, 8'd240, 0, "R4");
    idle();
    // R5 crosshatch
    wr(2'd0, 8'h05);
    drive(1, 1, 100, 1, 8'd44, 8'd33, 8'd22, 8'd16, 8'd128, 8'd128, 0, "R5");
    for (int row = 0; row < 70; row += 31) begin
      for (int col = 0; col < 200; col += 16) begin
        logic g;
        g = (col % 64 == 0) || (row % 32 == 0);
        drive(col, row, 100, 0, 8'd44, 8'd33, 8'd22,
              g ? 8'd81 : 8'd16, g ? 8'd90 : 8'd128, g ? 8'd240 : 8'd128, 0, "R5");
      end
    end
    idle();
    // R7 4:2:2 chroma reconstruction
    wr(2'd0, 8'h03);
    drive(0, 0, 100, 1, 8'd50, 8'h11, 8'h40, 8'd50, 8'd128, 8'h40, 0, "R7");
    drive(1, 0, 100, 0, 8'd51, 8'h11, 8'h50, 8'd51, 8'h50, 8'h40, 0, "R7");
    drive(2, 0, 100, 0, 8'd52, 8'h11, 8'h60, 8'd52, 8'h50, 8'h60, 0, "R7");
    drive(3, 0, 100, 0, 8'd53, 8'h11, 8'h70, 8'd53, 8'h70, 8'h60, 0, "R7");
    idle();
    // R8 VBI window
    wr(2'd0, 8'h11);
    std_720p = 0;
    drive(0, 0, 6, 1, 8'd60, 8'd61, 8'd62, 8'd60, 8'd61, 8'd62, 0, "R8");
    drive(0, 0, 7, 0, 8'd60, 8'd61, 8'd62, 8'd60, 8'd61, 8'd62, 1, "R8");
    drive(0, 0, 20, 0, 8'd60, 8'd61, 8'd62, 8'd60, 8'd61, 8'd62, 1, "R8");
    drive(0, 0, 21, 0, 8'd60, 8'd61, 8'd62, 8'd60, 8'd61, 8'd62, 0, "R8");
    idle();
    std_720p = 1;
    drive(0, 0, 5, 0, 8'd60, 8'd61, 8'd62, 8'd60, 8'd61, 8'd62, 0, "R8");
    drive(0, 0, 6, 0, 8'd60, 8'd61, 8'd62, 8'd60, 8'd61, 8'd62, 1, "R8");
    drive(0, 0, 25, 0, 8'd60, 8'd61, 8'd62, 8'd60, 8'd61, 8'd62, 1, "R8");
    drive(0, 0, 26, 0, 8'd60, 8'd61, 8'd62, 8'd60, 8'd61, 8'd62, 0, "R8");
    idle();
    wr(2'd0, 8'h01);
    drive(0, 0, 10, 1, 8'd60, 8'd61, 8'd62, 8'd60, 8'd61, 8'd62, 0, "R8");
    idle();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule